// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Detection

This block is the receive-side buffer of a 16550-compatible serial port. The receive shifter hands it one finished byte at a time. The host reads the oldest byte through a read strobe on the receive data register. A control-register write port switches queued mode on or off, flushes the contents and picks the fill threshold that drives the receive interrupt. The outputs are the oldest byte, a data-ready bit, a threshold-reached bit and a sticky overrun bit for the line status register.

In queued mode the buffer holds sixteen bytes plus one more byte in a holding stage that stands in for the shifter. A byte arriving while both are full overwrites the holding stage and raises overrun. Whenever a queue slot is free, the holding stage drains into it on the same edge. In single-register mode the buffer keeps one byte only. A new byte that arrives while that byte is unread replaces it and raises overrun.

Top module: `urx_buffer`

## Requirements
- R1: `ctl_wdata[0]` written through `ctl_we` selects queued mode (1) or single-register mode (0). `ctl_rdata` reads back as {`ctl_wdata[7:6]`, 5'b0, `ctl_wdata[0]`}, so bits 1 and 2 always read 0.
- R2: The threshold code in `ctl_wdata[7:6]` maps 2'b00 to 1 byte, 2'b01 to 4, 2'b10 to 8 and 2'b11 to 14.
- R3: In queued mode `level_hit` is 1 exactly when the stored byte count is at least the selected threshold. In single-register mode it equals `data_ready`.
- R4: In queued mode sixteen bytes are stored, and a seventeenth waits in the holding stage without raising `overrun`.
- R5: A byte that arrives while the queue is full and the holding stage is occupied, with no read in that cycle, replaces the holding byte and sets `overrun`. The sixteen stored bytes are unaffected.
- R6: `head_byte` shows the oldest stored byte, and reads through `rbr_rd` return the bytes in arrival order.
- R7: On the edge where a read frees a slot, the holding byte enters the queue. A byte that arrives afterwards is accepted without raising `overrun`.
- R8: A control write with bit 1 set, or one that changes bit 0, empties the queue and the holding stage, so `data_ready` is 0 after that edge. A byte pushed in the same cycle is dropped.
- R9: `overrun` stays set until a `stat_rd` strobe clears it. If a new overrun occurs in the same cycle as the strobe, the overrun wins.
- R10: In single-register mode a byte that arrives while `data_ready` is 1, with no read in that cycle, replaces the held byte and sets `overrun`.
- R11: `data_ready` is 1 exactly when at least one byte is stored. A read strobe while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive shifter presents a completed byte |
| rx_byte | input | 8 | Completed byte |
| rbr_rd | input | 1 | Host read of the receive data register (removes the oldest byte) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| stat_rd | input | 1 | Host read of the line status register (clears overrun) |
| head_byte | output | 8 | Oldest stored byte |
| data_ready | output | 1 | At least one byte is stored |
| level_hit | output | 1 | Stored count has reached the selected threshold |
| overrun | output | 1 | Sticky overrun flag |
| ctl_rdata | output | 8 | Control register readback |

## Verification
The assertions assume a single-byte push per cycle and a read strobe that lasts one clock per byte. They also assume that control writes are the only source of flushes. The bench keeps every strobe to one cycle and drives inputs on the falling edge. It fills the queue one byte at a time for every threshold code, so the count passes through each value from 0 to 16 before the holding stage and the overwrite case are reached. Reads, status reads and control writes are never combined with a push in the same cycle, except where a requirement names that combination.

// File: rtl/urx_pkg.sv
package urx_pkg;

   typedef enum logic [1:0] {
      LVL_ONE      = 2'b00,
      LVL_FOUR     = 2'b01,
      LVL_EIGHT    = 2'b10,
      LVL_FOURTEEN = 2'b11
   } lvl_code_t;

   localparam int unsigned LVL_MAX = 14;

   function automatic int unsigned lvl_bytes(input lvl_code_t code);
      case (code)
         LVL_ONE:   return 1;
         LVL_FOUR:  return 4;
         LVL_EIGHT: return 8;
         default:   return LVL_MAX;
      endcase
   endfunction

endpackage

// File: rtl/urx_store.sv
module urx_store #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic             ovw_en,
   input  logic [WIDTH-1:0] ovw_data,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count
);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [WIDTH-1:0] slot [DEPTH];

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot[g] <= '0;
            else if (!flush && wr_en && wr_ptr == PTR_W'(g))
               slot[g] <= wr_data;
            else if (!flush && ovw_en && rd_ptr == PTR_W'(g))
               slot[g] <= ovw_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
      end
   end

   assign head = slot[rd_ptr];

endmodule

// File: rtl/urx_hold.sv
module urx_hold #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             load,
   input  logic             drain,
   input  logic [WIDTH-1:0] din,
   output logic             valid,
   output logic [WIDTH-1:0] dout
);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (drain) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/urx_thresh.sv
module urx_thresh
   import urx_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             fifo_on,
   input  lvl_code_t        code,
   input  logic [CNT_W-1:0] count,
   output logic             hit
);

   logic [31:0] cnt_ext;
   assign cnt_ext = 32'(count);

   always_comb begin
      if (fifo_on)
         hit = cnt_ext >= lvl_bytes(code);
      else
         hit = cnt_ext != 0;
   end

endmodule

// File: rtl/urx_buffer.sv
module urx_buffer
   import urx_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [WIDTH-1:0] rx_byte,
   input  logic             rbr_rd,
   input  logic             ctl_we,
   input  logic [7:0]       ctl_wdata,
   input  logic             stat_rd,
   output logic [WIDTH-1:0] head_byte,
   output logic             data_ready,
   output logic             level_hit,
   output logic             overrun,
   output logic [7:0]       ctl_rdata
);

   initial begin
      if (WIDTH < 1) $error("urx_buffer: WIDTH must be at least 1");
      if ((1 << $clog2(DEPTH)) != DEPTH) $error("urx_buffer: DEPTH must be a power of two");
      if (DEPTH < LVL_MAX) $error("urx_buffer: DEPTH must cover the largest threshold");
   end

   logic             fifo_on;
   lvl_code_t        lvl_q;
   logic [CNT_W-1:0] cnt;
   logic             hold_v;
   logic [WIDTH-1:0] hold_d;

   logic flush, full, rd_eff, room;
   logic st_wr, st_ovw, h_load, h_drain, ovr_set;
   logic [WIDTH-1:0] st_data;

   // control register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_on <= 1'b0;
         lvl_q   <= LVL_ONE;
      end else if (ctl_we) begin
         fifo_on <= ctl_wdata[0];
         lvl_q   <= lvl_code_t'(ctl_wdata[7:6]);
      end
   end

   assign ctl_rdata = {lvl_q, 5'b0, fifo_on};
   assign flush     = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != fifo_on));

   // flow decisions
   assign full   = fifo_on ? (cnt == CNT_W'(DEPTH)) : (cnt != '0);
   assign rd_eff = rbr_rd && (cnt != '0);
   assign room   = !full || rd_eff;

   always_comb begin
      st_wr   = 1'b0;
      st_ovw  = 1'b0;
      h_load  = 1'b0;
      h_drain = 1'b0;
      ovr_set = 1'b0;
      st_data = rx_byte;
      if (!flush) begin
         if (fifo_on) begin
            st_wr   = room && (hold_v || rx_valid);
            st_data = hold_v ? hold_d : rx_byte;
            h_load  = rx_valid && (hold_v || !room);
            h_drain = hold_v && room && !rx_valid;
            ovr_set = rx_valid && hold_v && !room;
         end else begin
            st_wr   = rx_valid && room;
            st_ovw  = rx_valid && !room;
            ovr_set = st_ovw;
         end
      end
   end

   urx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (st_wr),
      .wr_data  (st_data),
      .rd_en    (rd_eff && !flush),
      .ovw_en   (st_ovw),
      .ovw_data (rx_byte),
      .head     (head_byte),
      .count    (cnt)
   );

   urx_hold #(.WIDTH(WIDTH)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .load  (h_load),
      .drain (h_drain),
      .din   (rx_byte),
      .valid (hold_v),
      .dout  (hold_d)
   );

   urx_thresh #(.CNT_W(CNT_W)) u_thresh (
      .fifo_on (fifo_on),
      .code    (lvl_q),
      .count   (cnt),
      .hit     (level_hit)
   );

   // sticky overrun, set has priority over clear
   always_ff @(posedge clk) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (ovr_set) overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
   end

   assign data_ready = cnt != '0;

endmodule

// File: rtl/urx_buffer_chk.sv
module urx_buffer_chk #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rbr_rd,
   input logic             ctl_we,
   input logic [7:0]       ctl_wdata,
   input logic             stat_rd,
   input logic             data_ready,
   input logic             level_hit,
   input logic             overrun,
   input logic [CNT_W-1:0] cnt,
   input logic             hold_v
);

   assert_hit_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level_hit |-> data_ready);

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   assert_hold_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v |-> cnt == CNT_W'(DEPTH));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[1]) |=> !data_ready && !hold_v);

   assert_ovr_needs_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_valid) && $past(data_ready));

   assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !rx_valid) |=> !overrun);

   assert_read_drops_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rbr_rd && data_ready && !rx_valid && !ctl_we && !hold_v)
      |=> cnt == $past(cnt) - 1'b1);

   assert_empty_read_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rbr_rd && !data_ready && !rx_valid && !ctl_we) |=> !data_ready);

endmodule

bind urx_buffer urx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rbr_rd     (rbr_rd),
   .ctl_we     (ctl_we),
   .ctl_wdata  (ctl_wdata),
   .stat_rd    (stat_rd),
   .data_ready (data_ready),
   .level_hit  (level_hit),
   .overrun    (overrun),
   .cnt        (cnt),
   .hold_v     (hold_v)
);

// File: tb/sim_urx_buffer.sv
module sim_urx_buffer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rbr_rd = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       stat_rd = 1'b0;
   logic [7:0] head_byte;
   logic       data_ready, level_hit, overrun;
   logic [7:0] ctl_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   urx_buffer u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rbr_rd(rbr_rd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
      .head_byte(head_byte), .data_ready(data_ready), .level_hit(level_hit),
      .overrun(overrun), .ctl_rdata(ctl_rdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int lvl_of(input int code);
      return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
   endfunction

   // each task drives at a falling edge and returns at the next falling edge
   task automatic push(input logic [7:0] b);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic pop();
      rbr_rd = 1'b1;
      @(negedge clk); rbr_rd = 1'b0;
   endtask

   task automatic ctl(input logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic lsr_read();
      stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset ready", data_ready, 0);
      chk("R9 reset overrun", overrun, 0);
      chk("R1 reset ctl", ctl_rdata, 0);

      // R1: bits 1 and 2 read back 0, flush leaves nothing ready
      ctl(8'hC7);
      chk("R1 readback", ctl_rdata, 8'hC1);
      chk("R8 flush ready", data_ready, 0);

      // sweep every threshold code through the full fill
      for (int code = 0; code < 4; code++) begin
         ctl(8'(code << 6) | 8'h03);
         chk("R2 code readback", ctl_rdata, (code << 6) | 1);
         chk("R3 empty no hit", level_hit, 0);
         for (int n = 1; n <= 16; n++) begin
            push(8'(n - 1 + code * 32));
            chk("R3 level hit", level_hit, (n >= lvl_of(code)) ? 1 : 0);
            chk("R11 ready", data_ready, 1);
            chk("R6 head oldest", head_byte, code * 32);
         end
         push(8'd16);
         chk("R4 seventeenth no overrun", overrun, 0);
         push(8'd17);
         chk("R5 overrun set", overrun, 1);
         chk("R5 head kept", head_byte, code * 32);
         lsr_read();
         chk("R9 overrun cleared", overrun, 0);
         pop();
         push(8'd18);
         chk("R7 accepted no overrun", overrun, 0);
         for (int k = 1; k < 16; k++) begin
            chk("R6 order", head_byte, k + code * 32);
            pop();
         end
         chk("R7 held byte moved", head_byte, 17);
         pop();
         chk("R7 late byte", head_byte, 18);
         pop();
         chk("R11 drained", data_ready, 0);
         pop();
         chk("R11 empty read ignored", data_ready, 0);
      end

      // R9: set wins over a same-cycle status read
      ctl(8'h01);
      for (int n = 0; n < 17; n++) push(8'(n));
      rx_valid = 1'b1; rx_byte = 8'hAA; stat_rd = 1'b1;
      @(negedge clk); rx_valid = 1'b0; stat_rd = 1'b0;
      chk("R9 set wins", overrun, 1);
      lsr_read();

      // R8: flush empties queue and holding stage; same-cycle push dropped
      ctl_we = 1'b1; ctl_wdata = 8'h03; rx_valid = 1'b1; rx_byte = 8'h55;
      @(negedge clk); ctl_we = 1'b0; rx_valid = 1'b0;
      chk("R8 flush with push", data_ready, 0);
      pop();
      chk("R8 holding cleared", data_ready, 0);

      // R10: single-register mode (mode change flushes)
      push(8'h33);
      ctl(8'h00);
      chk("R8 mode change flush", data_ready, 0);
      chk("R1 single mode", ctl_rdata, 0);
      push(8'h41);
      chk("R3 single hit", level_hit, 1);
      chk("R10 first byte", head_byte, 8'h41);
      chk("R10 no overrun yet", overrun, 0);
      push(8'h42);
      chk("R10 overrun", overrun, 1);
      chk("R10 replaced", head_byte, 8'h42);
      lsr_read();
      rx_valid = 1'b1; rx_byte = 8'h43; rbr_rd = 1'b1;
      @(negedge clk); rx_valid = 1'b0; rbr_rd = 1'b0;
      chk("R10 read plus push", overrun, 0);
      chk("R10 new byte", head_byte, 8'h43);
      pop();
      chk("R11 single empty", data_ready, 0);
      chk("R3 single no hit", level_hit, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule